// File: doc/BRIEF.md
# Command-Addressed Display Register Bank

This block sits between a host message link and a tile-based display engine. Each strobe carries an 8-bit command ID and a 16-bit operand. IDs in a window of 37 values starting at 192 are decoded. Most of them come in pairs: the even member reads a configuration register back and the odd member writes it. The registers hold the tile map, display, terminal, bitmap and palette pointers, two border colours, the fine scroll values, the screen width code, the operand registers of a copy/fill engine, and a sub-function code. All of them drive output ports continuously.

Four IDs form a memory window. They make one 8-bit or 16-bit access to graphics RAM at the address held in the source-address register. After each such access that register moves forward by a programmable 4-bit step. Every accepted command gives a one-cycle response on `rdValid`/`rdData` in the cycle after its strobe, so the host can send commands back to back.

Top module: `tileRegBank`

## Requirements
- R1: An ID below 192 or above 228 changes no register, starts no memory access and returns `rdData` = 0. A write command (odd offset below 34, or offset 36) also returns 0.
- R2: In the cycle after any strobe, `rdValid` is 1. After a cycle with no strobe, `rdValid` is 0. An even offset below 30 returns the register at pair index offset/2.
- R3: An odd offset below 30 writes the operand into pair index (offset-1)/2 and keeps only the field width. The fields and their widths are: sub-function (index 0) 2 bits, colours (6, 7) 8 bits, fine scrolls (8, 9) 3 bits, width code (10) 2 bits with 0=16, 1=32, 2=64 tiles, and all other indices 16 bits. The new value appears on the export port in the next cycle.
- R4: Offset 1 also raises `subFuncGo` for exactly the one cycle after its strobe.
- R5: Offset 30 raises `memReq` in the strobe cycle with `memWe`=0, `memWide`=0 and `memAddr` equal to the source address. In the next cycle `rdData` is {8'h00, `memRdData`[7:0]}.
- R6: Offset 32 makes a 16-bit read (`memWide`=1). In the next cycle `rdData` is the whole `memRdData` word.
- R7: Offsets 31 and 33 are memory writes (`memWe`=1). For offset 31, `memWrData` is the operand's low byte with the upper byte cleared. For offset 33 it is the whole operand.
- R8: After every memory access, the source address (pair index 11) becomes old value + step, modulo 2^16. The new value is seen in the next cycle. Without an access or a write to offset 23 it holds.
- R9: Offset 36 stores operand bits [3:0] as the step. Offset 35 reads the step back zero-extended.
- R10: Offset 34 returns `rasterLine` as sampled in the strobe cycle.
- R11: After reset, every export, the step, `rdValid` and `subFuncGo` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe |
| cmdId | input | 8 | Command ID |
| cmdWrData | input | 16 | Operand for write commands |
| rdValid | output | 1 | Response strobe, one cycle after a command |
| rdData | output | 16 | Response data |
| rasterLine | input | 8 | Current raster line from the display engine |
| memReq | output | 1 | Graphics RAM access request |
| memWe | output | 1 | RAM write enable |
| memWide | output | 1 | 1 = 16-bit access, 0 = 8-bit |
| memAddr | output | 16 | RAM address |
| memWrData | output | 16 | RAM write data |
| memRdData | input | 16 | RAM read data, one cycle after request |
| subFunc | output | 2 | Sub-function code |
| subFuncGo | output | 1 | Sub-function issue pulse |
| tileMapPtr | output | 16 | Tile map pointer |
| displayPtr | output | 16 | Display pointer |
| termPtr | output | 16 | Terminal pointer |
| bitmapPtr | output | 16 | Tile bitmap pointer |
| palettePtr | output | 16 | Palette pointer |
| topColor | output | 8 | Top border colour |
| botColor | output | 8 | Bottom border colour |
| fineHScroll | output | 3 | Fine horizontal scroll |
| fineVScroll | output | 3 | Fine vertical scroll |
| widthCode | output | 2 | Screen width code |
| srcAddr | output | 16 | Source address / memory pointer |
| dstAddr | output | 16 | Destination address |
| byteCount | output | 16 | Byte count |
| dataWord | output | 16 | Engine data word |
| autoStep | output | 4 | Pointer step |

## Verification
A memory access's response and the next command's decode can happen in the same cycle. In that cycle the RAM word for access N is steered to `rdData` while command N+1 is already using the pointer that access N just moved. The bench provokes this with runs of consecutive memory commands near the top of the address space, with a step of 15 so the pointer wraps. It also mixes in back-to-back pointer reads and writes. A bench model predicts each address and each response word from its own RAM pattern function, and it judges the pointer that every later access presents.

// File: rtl/tileRegPkg.sv
package tileRegPkg;
  localparam int DATA_W = 16;
  localparam int STEP_W = 4;
  localparam int NUM_CMDS = 37;
  localparam int NUM_PAIRS = 15;

  localparam logic [5:0] OFS_GO = 6'd1;
  localparam logic [5:0] OFS_SRC_WR = 6'd23;
  localparam logic [5:0] OFS_MEM_LO = 6'd30;
  localparam logic [5:0] OFS_MEM_HI = 6'd33;
  localparam logic [5:0] OFS_RASTER = 6'd34;
  localparam logic [5:0] OFS_STEP_RD = 6'd35;
  localparam logic [5:0] OFS_STEP_WR = 6'd36;

  localparam int IDX_SUB = 0;
  localparam int IDX_TOP = 6;
  localparam int IDX_BOT = 7;
  localparam int IDX_HSC = 8;
  localparam int IDX_VSC = 9;
  localparam int IDX_WID = 10;
  localparam int IDX_SRC = 11;

  typedef struct packed {
    logic       hit;
    logic       isWrite;
    logic       regWr;
    logic [3:0] regIdx;
    logic       memAcc;
    logic       memWrite;
    logic       memWide;
    logic       stepWr;
    logic [5:0] ofs;
  } ctlStrobesT;

  typedef struct packed {
    logic valid;
    logic fromMem;
    logic wide;
  } rspStateT;

  function automatic logic [DATA_W-1:0] pairMask(input int idx);
    case (idx)
      IDX_SUB, IDX_WID: return 16'h0003;
      IDX_TOP, IDX_BOT: return 16'h00FF;
      IDX_HSC, IDX_VSC: return 16'h0007;
      default:          return 16'hFFFF;
    endcase
  endfunction
endpackage

// File: rtl/tileRegCtrl.sv
module tileRegCtrl
  import tileRegPkg::*;
#(
  parameter int BASE_ID = 192
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [7:0] cmdId,
  output ctlStrobesT strb,
  output rspStateT   rsp,
  output logic       goQ
);
  localparam int LAST_ID = BASE_ID + NUM_CMDS - 1;

  logic       inRange;
  logic [7:0] rel;

  always_comb begin
    inRange = (int'(cmdId) >= BASE_ID) && (int'(cmdId) <= LAST_ID);
    rel = cmdId - 8'(BASE_ID);
    strb = '0;
    strb.ofs = rel[5:0];
    strb.hit = cmdValid && inRange;
    strb.isWrite = (strb.ofs < OFS_RASTER) ? strb.ofs[0] : (strb.ofs == OFS_STEP_WR);
    strb.memAcc = strb.hit && (strb.ofs >= OFS_MEM_LO) && (strb.ofs <= OFS_MEM_HI);
    strb.memWrite = strb.ofs[0];
    strb.memWide = strb.ofs[5];
    strb.regWr = strb.hit && strb.isWrite && (strb.ofs < OFS_MEM_LO);
    strb.regIdx = strb.ofs[4:1];
    strb.stepWr = strb.hit && (strb.ofs == OFS_STEP_WR);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rsp <= '0;
      goQ <= 1'b0;
    end else begin
      rsp.valid <= cmdValid;
      rsp.fromMem <= strb.memAcc && !strb.memWrite;
      rsp.wide <= strb.memWide;
      goQ <= strb.hit && (strb.ofs == OFS_GO);
    end
  end
endmodule

// File: rtl/tileRegPath.sv
module tileRegPath
  import tileRegPkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  ctlStrobesT                          strb,
  input  rspStateT                            rsp,
  input  logic [DATA_W-1:0]                   cmdWrData,
  input  logic [7:0]                          rasterLine,
  input  logic [DATA_W-1:0]                   memRdData,
  output logic [NUM_PAIRS-1:0][DATA_W-1:0]    pairQ,
  output logic [STEP_W-1:0]                   stepQ,
  output logic [DATA_W-1:0]                   rdData,
  output logic [DATA_W-1:0]                   memAddr,
  output logic [DATA_W-1:0]                   memWrData
);
  logic [DATA_W-1:0] pairR [NUM_PAIRS];
  logic [DATA_W-1:0] readVal;
  logic [DATA_W-1:0] rdHold;

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    if (k == IDX_SRC) begin : g_ptr
      always_ff @(posedge clk) begin
        if (!rstN) pairR[k] <= '0;
        else if (strb.memAcc) pairR[k] <= pairR[k] + {{(DATA_W-STEP_W){1'b0}}, stepQ};
        else if (strb.regWr && (int'(strb.regIdx) == k)) pairR[k] <= cmdWrData;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rstN) pairR[k] <= '0;
        else if (strb.regWr && (int'(strb.regIdx) == k)) pairR[k] <= cmdWrData & pairMask(k);
      end
    end
    assign pairQ[k] = pairR[k];
  end

  always_ff @(posedge clk) begin
    if (!rstN) stepQ <= '0;
    else if (strb.stepWr) stepQ <= cmdWrData[STEP_W-1:0];
  end

  always_comb begin
    readVal = '0;
    if (strb.hit && !strb.isWrite && !strb.memAcc) begin
      if (strb.ofs < OFS_MEM_LO) readVal = pairR[strb.regIdx];
      else if (strb.ofs == OFS_RASTER) readVal = {8'h00, rasterLine};
      else if (strb.ofs == OFS_STEP_RD) readVal = {{(DATA_W-STEP_W){1'b0}}, stepQ};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdHold <= '0;
    else rdHold <= readVal;
  end

  always_comb begin
    if (rsp.fromMem) rdData = rsp.wide ? memRdData : {8'h00, memRdData[7:0]};
    else rdData = rdHold;
  end

  assign memAddr = pairR[IDX_SRC];
  assign memWrData = strb.memWide ? cmdWrData : {8'h00, cmdWrData[7:0]};
endmodule

// File: rtl/tileRegBank.sv
module tileRegBank
  import tileRegPkg::*;
#(
  parameter int BASE_ID = 192
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [7:0]  cmdId,
  input  logic [15:0] cmdWrData,
  output logic        rdValid,
  output logic [15:0] rdData,
  input  logic [7:0]  rasterLine,
  output logic        memReq,
  output logic        memWe,
  output logic        memWide,
  output logic [15:0] memAddr,
  output logic [15:0] memWrData,
  input  logic [15:0] memRdData,
  output logic [1:0]  subFunc,
  output logic        subFuncGo,
  output logic [15:0] tileMapPtr,
  output logic [15:0] displayPtr,
  output logic [15:0] termPtr,
  output logic [15:0] bitmapPtr,
  output logic [15:0] palettePtr,
  output logic [7:0]  topColor,
  output logic [7:0]  botColor,
  output logic [2:0]  fineHScroll,
  output logic [2:0]  fineVScroll,
  output logic [1:0]  widthCode,
  output logic [15:0] srcAddr,
  output logic [15:0] dstAddr,
  output logic [15:0] byteCount,
  output logic [15:0] dataWord,
  output logic [3:0]  autoStep
);
  ctlStrobesT                         strb;
  rspStateT                           rsp;
  logic [NUM_PAIRS-1:0][DATA_W-1:0]   pairQ;
  logic                               unusedHiBits;

  tileRegCtrl #(.BASE_ID(BASE_ID)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdId(cmdId),
    .strb(strb), .rsp(rsp), .goQ(subFuncGo)
  );

  tileRegPath u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .rsp(rsp), .cmdWrData(cmdWrData),
    .rasterLine(rasterLine), .memRdData(memRdData), .pairQ(pairQ),
    .stepQ(autoStep), .rdData(rdData), .memAddr(memAddr), .memWrData(memWrData)
  );

  assign rdValid = rsp.valid;
  assign memReq = strb.memAcc;
  assign memWe = strb.memAcc && strb.memWrite;
  assign memWide = strb.memAcc && strb.memWide;

  assign subFunc = pairQ[0][1:0];
  assign tileMapPtr = pairQ[1];
  assign displayPtr = pairQ[2];
  assign termPtr = pairQ[3];
  assign bitmapPtr = pairQ[4];
  assign palettePtr = pairQ[5];
  assign topColor = pairQ[6][7:0];
  assign botColor = pairQ[7][7:0];
  assign fineHScroll = pairQ[8][2:0];
  assign fineVScroll = pairQ[9][2:0];
  assign widthCode = pairQ[10][1:0];
  assign srcAddr = pairQ[11];
  assign dstAddr = pairQ[12];
  assign byteCount = pairQ[13];
  assign dataWord = pairQ[14];

  assign unusedHiBits = ^{pairQ[0][15:2], pairQ[6][15:8], pairQ[7][15:8],
                          pairQ[8][15:3], pairQ[9][15:3], pairQ[10][15:2]};
endmodule

// File: rtl/tileRegChecker.sv
module tileRegChecker (
  input logic        clk,
  input logic        rstN,
  input logic        cmdValid,
  input logic [7:0]  cmdId,
  input logic        rdValid,
  input logic [15:0] rdData,
  input logic        memReq,
  input logic [15:0] srcAddr,
  input logic [3:0]  autoStep,
  input logic        subFuncGo
);
  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> rdValid);
  p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> !rdValid);
  p_out_range_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (cmdId < 8'd192 || cmdId > 8'd228)) |=> (rdData == 16'h0000));
  p_mem_only_window_r5: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (cmdValid && cmdId >= 8'd222 && cmdId <= 8'd225));
  p_src_advance_r8: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> (srcAddr == $past(srcAddr + {12'h000, autoStep})));
  p_src_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!memReq && !(cmdValid && cmdId == 8'd215)) |=> $stable(srcAddr));
  p_go_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdId == 8'd193) |=> subFuncGo);
  p_go_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && cmdId == 8'd193) |=> !subFuncGo);
  p_step_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && cmdId == 8'd228) |=> $stable(autoStep));
endmodule

bind tileRegBank tileRegChecker u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdId(cmdId),
  .rdValid(rdValid), .rdData(rdData), .memReq(memReq), .srcAddr(srcAddr),
  .autoStep(autoStep), .subFuncGo(subFuncGo)
);

// File: tb/tb_tileRegBank.sv
module tb_tileRegBank;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [7:0] cmdId = '0;
  logic [15:0] cmdWrData = '0;
  logic [7:0] rasterLine = '0;
  logic [15:0] memRdData = '0;
  logic rdValid, memReq, memWe, memWide, subFuncGo;
  logic [15:0] rdData, memAddr, memWrData;
  logic [1:0] subFunc, widthCode;
  logic [15:0] tileMapPtr, displayPtr, termPtr, bitmapPtr, palettePtr;
  logic [7:0] topColor, botColor;
  logic [2:0] fineHScroll, fineVScroll;
  logic [15:0] srcAddr, dstAddr, byteCount, dataWord;
  logic [3:0] autoStep;

  always #2.5 clk = ~clk;

  tileRegBank dut (.*);

  function automatic logic [15:0] memFn(input logic [15:0] a);
    return {a[7:0] ^ 8'hC3, a[15:8] + 8'h5A};
  endfunction

  always @(posedge clk) memRdData <= memFn(memAddr);

  int nVec = 0;
  int nBad = 0;
  logic [15:0] mPair [15];
  logic [3:0] mStep = '0;
  logic pValid = 1'b0;
  logic pGo = 1'b0;
  logic [15:0] pData = '0;
  string pTag = "R2";

  function automatic logic [15:0] fieldMask(input int idx);
    if (idx == 0 || idx == 10) return 16'h0003;
    if (idx == 6 || idx == 7) return 16'h00FF;
    if (idx == 8 || idx == 9) return 16'h0007;
    return 16'hFFFF;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkExports(input string req);
    chk({req, " subFunc"}, {14'h0, subFunc}, mPair[0]);
    chk({req, " tileMap"}, tileMapPtr, mPair[1]);
    chk({req, " display"}, displayPtr, mPair[2]);
    chk({req, " term"}, termPtr, mPair[3]);
    chk({req, " bitmap"}, bitmapPtr, mPair[4]);
    chk({req, " palette"}, palettePtr, mPair[5]);
    chk({req, " topColor"}, {8'h0, topColor}, mPair[6]);
    chk({req, " botColor"}, {8'h0, botColor}, mPair[7]);
    chk({req, " hScroll"}, {13'h0, fineHScroll}, mPair[8]);
    chk({req, " vScroll"}, {13'h0, fineVScroll}, mPair[9]);
    chk({req, " widthCode"}, {14'h0, widthCode}, mPair[10]);
    chk("R8 srcAddr", srcAddr, mPair[11]);
    chk({req, " dstAddr"}, dstAddr, mPair[12]);
    chk({req, " byteCount"}, byteCount, mPair[13]);
    chk({req, " dataWord"}, dataWord, mPair[14]);
    chk("R9 autoStep", {12'h0, autoStep}, {12'h0, mStep});
  endtask

  task automatic issue(input bit v, input logic [7:0] id, input logic [15:0] d);
    int off;
    bit inr, isMem;
    @(negedge clk);
    chk("R2 rdValid", {15'h0, rdValid}, {15'h0, pValid});
    if (pValid) chk(pTag, rdData, pData);
    chk("R4 subFuncGo", {15'h0, subFuncGo}, {15'h0, pGo});
    checkExports("R3/R1");
    rasterLine = 8'($urandom % 192);
    cmdValid = v; cmdId = id; cmdWrData = d;
    #1;
    inr = (id >= 8'd192) && (id <= 8'd228);
    off = int'(id) - 192;
    isMem = v && inr && off >= 30 && off <= 33;
    chk("R5 memReq", {15'h0, memReq}, {15'h0, isMem});
    if (isMem) begin
      chk("R5 memAddr", memAddr, mPair[11]);
      chk("R7 memWe", {15'h0, memWe}, {15'h0, 1'(off % 2)});
      chk("R6 memWide", {15'h0, memWide}, {15'h0, 1'(off >= 32)});
      if (off == 31) chk("R7 memWrData8", memWrData, {8'h0, d[7:0]});
      if (off == 33) chk("R7 memWrData16", memWrData, d);
    end
    pValid = v; pGo = v && inr && off == 1; pData = '0;
    pTag = inr ? "R2 rdData" : "R1 rdData";
    if (v && inr) begin
      if (off < 30 && off % 2 == 0) pData = mPair[off / 2];
      else if (off == 30) begin pData = {8'h0, memFn(mPair[11]) & 16'h00FF}; pTag = "R5 rdData8"; end
      else if (off == 32) begin pData = memFn(mPair[11]); pTag = "R6 rdData16"; end
      else if (off == 34) begin pData = {8'h0, rasterLine}; pTag = "R10 raster"; end
      else if (off == 35) begin pData = {12'h0, mStep}; pTag = "R9 stepRead"; end
      else pTag = "R1 writeZero";
      if (off < 30 && off % 2 == 1) mPair[off / 2] = d & fieldMask(off / 2);
      else if (isMem) mPair[11] = mPair[11] + {12'h0, mStep};
      else if (off == 36) mStep = d[3:0];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 15; i++) mPair[i] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    chk("R11 rdValid", {15'h0, rdValid}, 16'h0);
    chk("R11 go", {15'h0, subFuncGo}, 16'h0);
    checkExports("R11");
    // step of 15 and a pointer near the top so accesses wrap
    issue(1, 8'd228, 16'hFFFF);
    issue(1, 8'd215, 16'hFFF8);
    issue(1, 8'd224, 16'h0);
    issue(1, 8'd222, 16'h0);
    issue(1, 8'd225, 16'hBEEF);
    issue(1, 8'd223, 16'h12AB);
    issue(1, 8'd214, 16'h0);
    issue(1, 8'd227, 16'h0);
    // step of zero: pointer stays
    issue(1, 8'd228, 16'h0030);
    issue(1, 8'd224, 16'h0);
    issue(1, 8'd224, 16'h0);
    // field masks, width code and sub-function pulse
    issue(1, 8'd205, 16'h1234);
    issue(1, 8'd211, 16'hFFFF);
    issue(1, 8'd213, 16'h0002);
    issue(1, 8'd193, 16'h0003);
    issue(1, 8'd192, 16'h0);
    // out of range and read-only
    issue(1, 8'd191, 16'hAAAA);
    issue(1, 8'd229, 16'h5555);
    issue(1, 8'd226, 16'h7777);
    issue(0, 8'd195, 16'h9999);
    for (int n = 0; n < 1500; n++) begin
      logic [7:0] id;
      id = ($urandom % 8 == 0) ? 8'($urandom) : 8'(186 + $urandom % 48);
      issue(($urandom % 4) != 0, id, 16'($urandom));
    end
    issue(0, 8'd0, 16'h0);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule